// File: doc/BRIEF.md
# Dual Own-Address Matcher with Low-Power Wakeup

This block decides whether an I2C slave answers the address phase of a transfer. It checks the received address byte or bytes against two own-address slots. Slot 1 holds either a 7-bit or a 10-bit address. Slot 2 holds a 7-bit address, and a mask field can drop its low-order bits from the compare, so that one slot answers a whole group of addresses. The bit shifter and the pad drivers sit outside the block. The shifter hands over each received byte with a completion strobe, and a separate strobe marks each start condition.

The block reports whether an address matched, which slot matched, and whether the current byte is acknowledged. A small sequencer handles the case where the chip is asleep and the kernel clock is off:
- A start condition raises a clock request, and SCL is held low until the clock reports ready.
- If the address then matches, a wakeup interrupt is raised and SCL stays low until the system acknowledges the wakeup.
- If the address does not match, the clock request and the SCL hold are both released without an interrupt.

While wakeup is enabled, the digital glitch filter setting passed to the pad logic is forced to zero.

Top module: `ownaddr_top`

## Requirements
- R1: With slot 1 enabled in 7-bit mode, a first byte whose bits [7:1] equal the slot's 7-bit address makes the block do three things in the cycle after the byte strobe: set `ackOut`, set `addrMatch`, and set `matchSlot` to 2'b01. A byte with any other address leaves all three clear.
- R2: With slot 1 in 10-bit mode, the first byte is acknowledged without a match when its bits [7:3] are 5'b11110 and bits [2:1] equal address bits [9:8]. A full slot-1 match follows only if the second byte equals address bits [7:0]. Any other first byte, or a differing second byte, gives no acknowledge and no match.
- R3: For slot 2, a mask value k from 0 to 6 leaves the k lowest address bits out of the compare, and the remaining bits must all be equal. When it matches, `matchSlot` is 2'b10.
- R4: A slot-2 mask value of 7 matches any 7-bit address except the reserved groups whose upper four bits are 4'b0000 or 4'b1111.
- R5: When both slots match the same byte, slot 1 wins and `matchSlot` is 2'b01. `matchSlot` is always one-hot while `addrMatch` is set and zero otherwise. A slot-2 match on the first byte ends the address phase.
- R6: A disabled slot never matches. After reset, and in the cycle after any start strobe, `addrMatch`, `ackOut` and `matchSlot` are clear.
- R7: A start strobe seen while `sleepMode`, `wakeEn` and `stretchEn` are all high has these effects from the next cycle on:
  - `clkReq` and `sclHold` are raised.
  - `sclHold` stays high until `clkReady` is seen.
  - `clkReq` stays high throughout the address phase.
- R8: An address match during a wakeup address phase raises `wakeIrq` in the cycle after the byte strobe. `wakeIrq`, `sclHold` and `clkReq` then stay high until `wakeAck` is seen, and all three are low in the cycle after it.
- R9: An address mismatch during a wakeup address phase leaves `clkReq`, `sclHold` and `wakeIrq` all low in the cycle after the byte strobe.
- R10: `filtEff` is zero while `wakeEn` is high, and otherwise equals `filtCfg`.
- R11: A start strobe while not asleep, or with `wakeEn` or `stretchEn` low, raises neither `clkReq` nor `sclHold`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Kernel clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startDet | input | 1 | One-cycle strobe: start or repeated start seen |
| addrStb | input | 1 | One-cycle strobe: `addrByte` holds a complete received byte |
| addrByte | input | 8 | Received byte; for 7-bit addresses bits [7:1] are the address and bit 0 is the direction |
| oa1En | input | 1 | Slot 1 enable |
| oa1Mode10 | input | 1 | Slot 1 uses 10-bit addressing |
| oa1Addr | input | 10 | Slot 1 address (7-bit mode uses bits [6:0]) |
| oa2En | input | 1 | Slot 2 enable |
| oa2Addr | input | 7 | Slot 2 address |
| oa2Mask | input | 3 | Slot 2 low-bit mask (0 to 6 bits ignored; 7 matches all non-reserved) |
| sleepMode | input | 1 | System is in low-power mode |
| wakeEn | input | 1 | Wakeup on address match enabled |
| stretchEn | input | 1 | Clock stretching enabled |
| clkReady | input | 1 | Requested kernel clock is running |
| wakeAck | input | 1 | System reports that it has woken up |
| filtCfg | input | FILT_W | Configured digital filter length |
| filtEff | output | FILT_W | Filter length applied to the pads |
| addrMatch | output | 1 | Full address matched since the last start |
| matchSlot | output | 2 | One-hot slot that matched: bit 0 slot 1, bit 1 slot 2 |
| ackOut | output | 1 | Acknowledge the last address byte |
| clkReq | output | 1 | Kernel clock request |
| sclHold | output | 1 | Hold SCL low |
| wakeIrq | output | 1 | Wakeup interrupt |

## Verification
The bench builds the block with its default filter width of four bits. This allows a nonzero filter setting that differs from the forced value of zero. The 7-bit and 10-bit address widths and the three-bit mask field are fixed by the protocol. A single vector walk therefore covers these cases:
- every mask class, including the reserved-group rule for mask 7;
- both 10-bit failure points;
- slot priority.

Directed sequences drive the wakeup path through clock wait, match hold and mismatch release.

// File: rtl/ownaddr_pkg.sv
package ownaddr_pkg;
  localparam int ADDR7_W  = 7;
  localparam int ADDR10_W = 10;
  localparam int MASK_W   = 3;
  localparam int BYTE_W   = 8;
  localparam logic [4:0] HDR10 = 5'b11110;

  // control -> datapath strobes
  typedef struct packed {
    logic clear;
    logic loadFirst;
    logic loadSecond;
  } dpStrobe_t;

  // datapath -> control compare results
  typedef struct packed {
    logic firstFull;
    logic firstHdr;
    logic secondHit;
  } cmpRes_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAITCLK, ST_ADDR1, ST_ADDR2, ST_WAKEHOLD
  } ctlState_t;
endpackage

// File: rtl/ownaddr_dp.sv
module ownaddr_dp
  import ownaddr_pkg::*;
#(
  parameter int FILT_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strb,
  input  logic [BYTE_W-1:0]   addrByte,
  input  logic                oa1En,
  input  logic                oa1Mode10,
  input  logic [ADDR10_W-1:0] oa1Addr,
  input  logic                oa2En,
  input  logic [ADDR7_W-1:0]  oa2Addr,
  input  logic [MASK_W-1:0]   oa2Mask,
  input  logic                wakeEn,
  input  logic [FILT_W-1:0]   filtCfg,
  output cmpRes_t             cmp,
  output logic                addrMatch,
  output logic [1:0]          matchSlot,
  output logic                ackOut,
  output logic [FILT_W-1:0]   filtEff
);
  localparam logic [MASK_W-1:0]  MASK_ALL = {MASK_W{1'b1}};
  localparam logic [ADDR7_W-1:0] ONES7    = {ADDR7_W{1'b1}};

  logic [ADDR7_W-1:0] rxAddr;
  logic [ADDR7_W-1:0] careMask;
  logic hit1Seven, hit2, hdrHit, lowHit, reservedAddr, maskedHit;

  assign rxAddr       = addrByte[BYTE_W-1:1];
  assign careMask     = ONES7 << oa2Mask;
  assign maskedHit    = ((rxAddr ^ oa2Addr) & careMask) == '0;
  assign reservedAddr = (rxAddr[ADDR7_W-1 -: 4] == 4'b0000) ||
                        (rxAddr[ADDR7_W-1 -: 4] == 4'b1111);

  assign hit1Seven = oa1En && !oa1Mode10 && (rxAddr == oa1Addr[ADDR7_W-1:0]);
  assign hit2      = oa2En && ((oa2Mask == MASK_ALL) ? !reservedAddr : maskedHit);
  assign hdrHit    = oa1En && oa1Mode10 && (addrByte[7:3] == HDR10) &&
                     (addrByte[2:1] == oa1Addr[ADDR10_W-1 -: 2]);
  assign lowHit    = oa1En && oa1Mode10 && (addrByte == oa1Addr[BYTE_W-1:0]);

  always_comb begin
    cmp.firstFull = hit1Seven || hit2;
    cmp.firstHdr  = hdrHit && !(hit1Seven || hit2);
    cmp.secondHit = lowHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrMatch <= 1'b0;
      matchSlot <= 2'b00;
      ackOut    <= 1'b0;
    end else if (strb.clear) begin
      addrMatch <= 1'b0;
      matchSlot <= 2'b00;
      ackOut    <= 1'b0;
    end else if (strb.loadFirst) begin
      addrMatch <= hit1Seven || hit2;
      matchSlot <= hit1Seven ? 2'b01 : (hit2 ? 2'b10 : 2'b00);
      ackOut    <= hit1Seven || hit2 || hdrHit;
    end else if (strb.loadSecond) begin
      addrMatch <= lowHit;
      matchSlot <= lowHit ? 2'b01 : 2'b00;
      ackOut    <= lowHit;
    end
  end

  assign filtEff = wakeEn ? '0 : filtCfg;

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.clear, strb.loadFirst, strb.loadSecond}));
  // R5
  slot_consistent_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchSlot) && (addrMatch == (matchSlot != 2'b00)));
  // R6
  start_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> !addrMatch && !ackOut);
endmodule

// File: rtl/ownaddr_ctl.sv
module ownaddr_ctl
  import ownaddr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startDet,
  input  logic      addrStb,
  input  logic      sleepMode,
  input  logic      wakeEn,
  input  logic      stretchEn,
  input  logic      clkReady,
  input  logic      wakeAck,
  input  cmpRes_t   cmp,
  input  logic      addrMatch,
  output dpStrobe_t strb,
  output logic      clkReq,
  output logic      sclHold,
  output logic      wakeIrq
);
  ctlState_t state, stateNext;
  logic wakeFlow, wakeArm;

  assign wakeArm = sleepMode && wakeEn && stretchEn;

  always_comb begin
    stateNext = state;
    strb      = '0;
    unique case (state)
      ST_IDLE, ST_ADDR1, ST_ADDR2: begin
        if (startDet) begin
          strb.clear = 1'b1;
          stateNext  = wakeArm ? ST_WAITCLK : ST_ADDR1;
        end else if (addrStb && state == ST_ADDR1) begin
          strb.loadFirst = 1'b1;
          if (cmp.firstFull)     stateNext = wakeFlow ? ST_WAKEHOLD : ST_IDLE;
          else if (cmp.firstHdr) stateNext = ST_ADDR2;
          else                   stateNext = ST_IDLE;
        end else if (addrStb && state == ST_ADDR2) begin
          strb.loadSecond = 1'b1;
          stateNext = (cmp.secondHit && wakeFlow) ? ST_WAKEHOLD : ST_IDLE;
        end
      end
      ST_WAITCLK:  if (clkReady) stateNext = ST_ADDR1;
      ST_WAKEHOLD: if (wakeAck)  stateNext = ST_IDLE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      wakeFlow <= 1'b0;
    end else begin
      state <= stateNext;
      if (strb.clear) wakeFlow <= wakeArm;
    end
  end

  assign clkReq  = wakeFlow && (state != ST_IDLE);
  assign sclHold = (state == ST_WAITCLK) || (state == ST_WAKEHOLD);
  assign wakeIrq = (state == ST_WAKEHOLD);

  // R7
  clk_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAITCLK && !clkReady) |=> sclHold && clkReq);
  // R8
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wakeIrq && !wakeAck) |=> wakeIrq && sclHold);
  // R8
  irq_needs_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeIrq |-> addrMatch);
  // R11
  no_wake_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wakeFlow |-> !clkReq && !wakeIrq);
endmodule

// File: rtl/ownaddr_top.sv
module ownaddr_top
  import ownaddr_pkg::*;
#(
  parameter int FILT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startDet,
  input  logic              addrStb,
  input  logic [7:0]        addrByte,
  input  logic              oa1En,
  input  logic              oa1Mode10,
  input  logic [9:0]        oa1Addr,
  input  logic              oa2En,
  input  logic [6:0]        oa2Addr,
  input  logic [2:0]        oa2Mask,
  input  logic              sleepMode,
  input  logic              wakeEn,
  input  logic              stretchEn,
  input  logic              clkReady,
  input  logic              wakeAck,
  input  logic [FILT_W-1:0] filtCfg,
  output logic [FILT_W-1:0] filtEff,
  output logic              addrMatch,
  output logic [1:0]        matchSlot,
  output logic              ackOut,
  output logic              clkReq,
  output logic              sclHold,
  output logic              wakeIrq
);
  dpStrobe_t strb;
  cmpRes_t   cmp;

  ownaddr_dp #(.FILT_W(FILT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .addrByte(addrByte),
    .oa1En(oa1En), .oa1Mode10(oa1Mode10), .oa1Addr(oa1Addr),
    .oa2En(oa2En), .oa2Addr(oa2Addr), .oa2Mask(oa2Mask),
    .wakeEn(wakeEn), .filtCfg(filtCfg), .cmp(cmp),
    .addrMatch(addrMatch), .matchSlot(matchSlot), .ackOut(ackOut),
    .filtEff(filtEff)
  );

  ownaddr_ctl u_ctl (
    .clk(clk), .rstN(rstN), .startDet(startDet), .addrStb(addrStb),
    .sleepMode(sleepMode), .wakeEn(wakeEn), .stretchEn(stretchEn),
    .clkReady(clkReady), .wakeAck(wakeAck), .cmp(cmp),
    .addrMatch(addrMatch), .strb(strb), .clkReq(clkReq),
    .sclHold(sclHold), .wakeIrq(wakeIrq)
  );
endmodule

// File: tb/ownaddr_top_tb.sv
module ownaddr_top_tb;
  localparam int FILT_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startDet = 0, addrStb = 0;
  logic [7:0] addrByte = '0;
  logic oa1En = 0, oa1Mode10 = 0, oa2En = 0;
  logic [9:0] oa1Addr = '0;
  logic [6:0] oa2Addr = '0;
  logic [2:0] oa2Mask = '0;
  logic sleepMode = 0, wakeEn = 0, stretchEn = 1, clkReady = 0, wakeAck = 0;
  logic [FILT_W-1:0] filtCfg = '0;
  logic [FILT_W-1:0] filtEff;
  logic addrMatch, ackOut, clkReq, sclHold, wakeIrq;
  logic [1:0] matchSlot;

  int nRun = 0, nFail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ownaddr_top #(.FILT_W(FILT_W)) u_dut (.*);

  typedef struct packed {
    logic       e1;
    logic       m10;
    logic [9:0] a1;
    logic       e2;
    logic [6:0] a2;
    logic [2:0] mk;
    logic       two;
    logic [7:0] b0;
    logic [7:0] b1;
    logic       xAck;
    logic       xMatch;
    logic [1:0] xSlot;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,10'h02A,1'b0,7'h00,3'd0,1'b0,8'h54,8'h00,1'b1,1'b1,2'b01}, // R1 hit
    '{1'b1,1'b0,10'h02A,1'b0,7'h00,3'd0,1'b0,8'h56,8'h00,1'b0,1'b0,2'b00}, // R1 miss
    '{1'b1,1'b1,10'h2C5,1'b0,7'h00,3'd0,1'b1,8'hF4,8'hC5,1'b1,1'b1,2'b01}, // R2 hit
    '{1'b1,1'b1,10'h2C5,1'b0,7'h00,3'd0,1'b1,8'hF4,8'hC4,1'b0,1'b0,2'b00}, // R2 low miss
    '{1'b1,1'b1,10'h2C5,1'b0,7'h00,3'd0,1'b0,8'hF2,8'h00,1'b0,1'b0,2'b00}, // R2 hdr miss
    '{1'b0,1'b0,10'h000,1'b1,7'h35,3'd0,1'b0,8'h6A,8'h00,1'b1,1'b1,2'b10}, // R3 exact
    '{1'b0,1'b0,10'h000,1'b1,7'h35,3'd2,1'b0,8'h6C,8'h00,1'b1,1'b1,2'b10}, // R3 masked
    '{1'b0,1'b0,10'h000,1'b1,7'h35,3'd2,1'b0,8'h62,8'h00,1'b0,1'b0,2'b00}, // R3 bit2 off
    '{1'b0,1'b0,10'h000,1'b1,7'h35,3'd6,1'b0,8'h00,8'h00,1'b1,1'b1,2'b10}, // R3 mask6
    '{1'b0,1'b0,10'h000,1'b1,7'h35,3'd7,1'b0,8'h20,8'h00,1'b1,1'b1,2'b10}, // R4 any
    '{1'b0,1'b0,10'h000,1'b1,7'h35,3'd7,1'b0,8'h0A,8'h00,1'b0,1'b0,2'b00}, // R4 rsv low
    '{1'b0,1'b0,10'h000,1'b1,7'h35,3'd7,1'b0,8'hF8,8'h00,1'b0,1'b0,2'b00}, // R4 rsv high
    '{1'b1,1'b0,10'h02A,1'b1,7'h2A,3'd0,1'b0,8'h54,8'h00,1'b1,1'b1,2'b01}, // R5 prio
    '{1'b1,1'b0,10'h02A,1'b1,7'h2B,3'd0,1'b0,8'h56,8'h00,1'b1,1'b1,2'b10}, // R5 slot2
    '{1'b0,1'b0,10'h02A,1'b0,7'h2A,3'd0,1'b0,8'h54,8'h00,1'b0,1'b0,2'b00}, // R6 disabled
    '{1'b1,1'b1,10'h2C5,1'b1,7'h10,3'd7,1'b1,8'hF4,8'hC5,1'b1,1'b1,2'b01}  // R5 10b+mask7
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) startDet = 1'b1;
    @(negedge clk) startDet = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk) begin addrByte = b; addrStb = 1'b1; end
    @(negedge clk) addrStb = 1'b0;
  endtask

  task automatic finish();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R6 reset state
    check("R6 reset match", addrMatch, 0);
    check("R6 reset ack", ackOut, 0);
    check("R6 reset slot", matchSlot, 0);
    check("R7 reset clkReq", clkReq, 0);
    check("R8 reset irq", wakeIrq, 0);

    for (int i = 0; i < NV; i++) begin
      oa1En = VECS[i].e1; oa1Mode10 = VECS[i].m10; oa1Addr = VECS[i].a1;
      oa2En = VECS[i].e2; oa2Addr = VECS[i].a2; oa2Mask = VECS[i].mk;
      pulseStart();
      sendByte(VECS[i].b0);
      if (VECS[i].two) begin
        check($sformatf("R2 vec%0d hdr ack", i), ackOut, 1);
        check($sformatf("R2 vec%0d hdr nomatch", i), addrMatch, 0);
        sendByte(VECS[i].b1);
      end
      check($sformatf("vec%0d ack (R1-5)", i), ackOut, VECS[i].xAck);
      check($sformatf("vec%0d match (R1-5)", i), addrMatch, VECS[i].xMatch);
      check($sformatf("vec%0d slot (R1-5)", i), matchSlot, VECS[i].xSlot);
    end

    // R6 start clears a held match
    oa1En = 1; oa1Mode10 = 0; oa1Addr = 10'h02A; oa2En = 0;
    pulseStart(); sendByte(8'h54);
    check("R6 pre-clear match", addrMatch, 1);
    pulseStart();
    check("R6 start clears match", addrMatch, 0);
    check("R6 start clears ack", ackOut, 0);

    // R10 filter forcing
    filtCfg = 4'd5; wakeEn = 0;
    @(negedge clk) check("R10 filter passes", filtEff, 5);
    wakeEn = 1;
    @(negedge clk) check("R10 filter forced", filtEff, 0);

    // R11 not asleep: no clock request or hold
    sleepMode = 0;
    pulseStart();
    check("R11 awake clkReq", clkReq, 0);
    check("R11 awake hold", sclHold, 0);
    sleepMode = 1; stretchEn = 0;
    pulseStart();
    check("R11 nostretch clkReq", clkReq, 0);
    check("R11 nostretch hold", sclHold, 0);
    stretchEn = 1;

    // R7 clock wait
    clkReady = 0;
    pulseStart();
    check("R7 clkReq up", clkReq, 1);
    check("R7 hold up", sclHold, 1);
    repeat (3) @(negedge clk);
    check("R7 hold while waiting", sclHold, 1);
    clkReady = 1;
    @(negedge clk);
    check("R7 hold released", sclHold, 0);
    check("R7 clkReq kept", clkReq, 1);

    // R8 match wake
    sendByte(8'h54);
    check("R8 irq", wakeIrq, 1);
    check("R8 hold", sclHold, 1);
    check("R8 clkReq", clkReq, 1);
    repeat (2) @(negedge clk);
    check("R8 irq held", wakeIrq, 1);
    @(negedge clk) wakeAck = 1;
    @(negedge clk) wakeAck = 0;
    check("R8 irq after ack", wakeIrq, 0);
    check("R8 hold after ack", sclHold, 0);
    check("R8 clkReq after ack", clkReq, 0);

    // R9 mismatch
    pulseStart();
    check("R9 clkReq at start", clkReq, 1);
    @(negedge clk);
    sendByte(8'h56);
    check("R9 clkReq dropped", clkReq, 0);
    check("R9 no irq", wakeIrq, 0);
    check("R9 no hold", sclHold, 0);
    check("R9 no ack", ackOut, 0);

    finished = 1;
    finish();
  end
endmodule